// File: doc/BRIEF.md
# Masked PHY Event Interrupt Controller

This block gathers seven status lines from a physical-layer transceiver and turns them into one active-low interrupt request. Each status line has a sticky event flag, set by the edge that marks the event, and a mask bit that decides whether that flag may pull the interrupt low. Six lines signal an event on a low-to-high transition. The link-status line signals an event on a high-to-low transition, because the event of interest is the link going down.

Software reaches the flags and masks through a plain single-cycle register port. The port has a select bit, a write strobe, write data, and combinational read data. A flag is cleared only by writing a one to it, and only once its source has gone back to its resting level. The energy-detect flag comes out of reset already set, because that status powers up active. If the energy status then drops before software has touched the flag, the flag clears by itself.

Top module: `phy_irq_ctrl`

## Requirements
- R1: After reset the flag register reads 0x0080, with only the energy-detect flag set, the mask register reads 0x0000 and `irq_n` is 1.
- R2: Register bit positions: flag and mask bit k+1 belong to `stat_in[k]`. The mapping is energy detect `stat_in[6]` to bit 7, negotiation done [5] to bit 6, remote fault [4] to bit 5, link status [3] to bit 4, partner acknowledge [2] to bit 3, parallel-detect fault [1] to bit 2, and page received [0] to bit 1. A low-to-high change on any line other than link status sets its flag.
- R3: A high-to-low change on the link-status line sets flag bit 4. A low-to-high change on that line sets nothing.
- R4: A write to the flag register (`reg_sel`=0) with a one in a flag's bit clears that flag, provided its source is at rest. Rest is low for the six rising-edge lines and high for link status. Flags written with zero are unchanged.
- R5: A write of one to a flag whose source is still active leaves the flag set.
- R6: When a setting edge and a write-one clear of the same flag fall in the same cycle, the flag ends up set.
- R7: A write to the mask register (`reg_sel`=1) replaces mask bits 7..1. A set flag whose mask bit is 0 does not drive `irq_n` low.
- R8: `irq_n` is a register. It is 0 exactly when, in the previous cycle, some flag and its mask bit were both 1. It therefore follows a flag or mask update one cycle later.
- R9: Writing 0 to a mask bit releases `irq_n` without changing the flag.
- R10: While the energy-detect flag still holds its power-up value, a low on `stat_in[6]` clears that flag with no write.
- R11: Register bits 0 and 15..8 always read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stat_in | input | 7 | Status lines, mapped as in R2 |
| reg_sel | input | 1 | Register select: 0 flags, 1 masks |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| irq_n | output | 1 | Interrupt request, active low |

## Verification
The bench attacks the clear rule from both sides: a write-one while the source is still active, and a write-one in the same cycle as a new edge. A design that cleared unconditionally would lose the event in both cases. It drives the link line in both directions, so that a polarity mix-up shows up as a spurious or missing link-down flag. It follows the energy-detect power-up flag through its self-clear, which a design without that rule would leave stuck. It counts cycles from a mask write to `irq_n`, which exposes both a missing output register and an extra one. It also confirms that clearing a mask releases the interrupt while the flag survives.

// File: rtl/phyirq_pkg.sv
package phyirq_pkg;
    localparam int NUM_SRC  = 7;
    localparam int REG_W    = 16;
    localparam int FLAG_LSB = 1;

    typedef logic [NUM_SRC-1:0] src_vec_t;
    typedef logic [REG_W-1:0]   reg_word_t;

    typedef enum logic {
        SEL_FLAG = 1'b0,
        SEL_MASK = 1'b1
    } reg_sel_e;

    // Link status is the one line whose event is a falling edge
    localparam src_vec_t FALL_SRC   = 7'b0001000;
    // Energy detect powers up active, so its flag resets set
    localparam src_vec_t PWRUP_FLAG = 7'b1000000;
    localparam int       PWRUP_IDX  = 6;

    typedef struct packed {
        src_vec_t hit;   // triggering edge seen this cycle
        src_vec_t idle;  // source at its resting level
    } edge_info_t;

    function automatic reg_word_t pack_reg(input src_vec_t v);
        reg_word_t w;
        w = '0;
        w[FLAG_LSB +: NUM_SRC] = v;
        return w;
    endfunction

    function automatic src_vec_t unpack_reg(input reg_word_t w);
        return w[FLAG_LSB +: NUM_SRC];
    endfunction
endpackage

// File: rtl/phyirq_edge.sv
module phyirq_edge
    import phyirq_pkg::*;
#(
    parameter src_vec_t FALL_MASK = FALL_SRC
) (
    input  logic       clk,
    input  logic       rst,
    input  src_vec_t   stat,
    output edge_info_t info
);
    src_vec_t prev_q;

    // During reset track the inputs so release creates no false edge
    always_ff @(posedge clk) begin
        prev_q <= stat;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        if (FALL_MASK[i]) begin : g_fall
            assign info.hit[i]  = prev_q[i] & ~stat[i] & ~rst;
            assign info.idle[i] = stat[i];
        end else begin : g_rise
            assign info.hit[i]  = ~prev_q[i] & stat[i] & ~rst;
            assign info.idle[i] = ~stat[i];
        end
    end
endmodule

// File: rtl/phyirq_flags.sv
module phyirq_flags
    import phyirq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  edge_info_t info,
    input  src_vec_t   clr_req,
    output src_vec_t   flag_q
);
    logic     pend_q;
    src_vec_t flag_d;

    // Power-up hold: cleared once the energy line is first seen at rest
    always_ff @(posedge clk) begin
        if (rst)
            pend_q <= 1'b1;
        else if (info.idle[PWRUP_IDX])
            pend_q <= 1'b0;
    end

    always_comb begin
        for (int i = 0; i < NUM_SRC; i++) begin
            if (info.hit[i])
                flag_d[i] = 1'b1;
            else if (clr_req[i] && info.idle[i])
                flag_d[i] = 1'b0;
            else if (PWRUP_FLAG[i] && pend_q && info.idle[i])
                flag_d[i] = 1'b0;
            else
                flag_d[i] = flag_q[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            flag_q <= PWRUP_FLAG;
        else
            flag_q <= flag_d;
    end
endmodule

// File: rtl/phyirq_out.sv
module phyirq_out
    import phyirq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     mask_wr,
    input  src_vec_t mask_wdata,
    input  src_vec_t flag_q,
    output src_vec_t mask_q,
    output logic     irq_n
);
    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else if (mask_wr)
            mask_q <= mask_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)
            irq_n <= 1'b1;
        else
            irq_n <= ~|(flag_q & mask_q);
    end
endmodule

// File: rtl/phy_irq_ctrl.sv
module phy_irq_ctrl
    import phyirq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [6:0]  stat_in,
    input  logic        reg_sel,
    input  logic        reg_wr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic        irq_n
);
    reg_sel_e   sel;
    edge_info_t info;
    src_vec_t   clr_req;
    src_vec_t   flag_vec;
    src_vec_t   mask_vec;
    logic       mask_wr;

    assign sel     = reg_sel_e'(reg_sel);
    assign clr_req = (reg_wr && sel == SEL_FLAG) ? unpack_reg(reg_wdata) : '0;
    assign mask_wr = reg_wr && sel == SEL_MASK;

    phyirq_edge #(.FALL_MASK(FALL_SRC)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .stat (stat_in),
        .info (info)
    );

    phyirq_flags u_flags (
        .clk     (clk),
        .rst     (rst),
        .info    (info),
        .clr_req (clr_req),
        .flag_q  (flag_vec)
    );

    phyirq_out u_out (
        .clk        (clk),
        .rst        (rst),
        .mask_wr    (mask_wr),
        .mask_wdata (unpack_reg(reg_wdata)),
        .flag_q     (flag_vec),
        .mask_q     (mask_vec),
        .irq_n      (irq_n)
    );

    assign reg_rdata = (sel == SEL_FLAG) ? pack_reg(flag_vec) : pack_reg(mask_vec);
endmodule

// File: rtl/phyirq_chk.sv
module phyirq_chk
    import phyirq_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic [6:0]  stat_in,
    input logic [6:0]  flag_q,
    input logic [6:0]  mask_q,
    input logic        irq_n,
    input logic        reg_wr,
    input logic        reg_sel
);
    // R8: output follows the masked flags of the previous cycle
    a_r8_irq_tracks: assert property (@(posedge clk) disable iff (rst)
        irq_n == !$past(|(flag_q & mask_q)));

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_chk
        if (FALL_SRC[i]) begin : g_fall
            // R3: link falling edge latches its flag
            a_r3_link_fall_sets: assert property (@(posedge clk) disable iff (rst)
                $fell(stat_in[i]) |=> flag_q[i]);
            // R5: flag held while link still down
            a_r5_link_active_holds: assert property (@(posedge clk) disable iff (rst)
                (flag_q[i] && !stat_in[i]) |=> flag_q[i]);
        end else begin : g_rise
            // R2: rising edge latches the flag
            a_r2_rise_sets: assert property (@(posedge clk) disable iff (rst)
                $rose(stat_in[i]) |=> flag_q[i]);
            // R5: flag held while the source is still active
            a_r5_active_holds: assert property (@(posedge clk) disable iff (rst)
                (flag_q[i] && stat_in[i]) |=> flag_q[i]);
        end
        if (!PWRUP_FLAG[i]) begin : g_nopwr
            // R4: without a flag write, a set flag stays set
            a_r4_clear_needs_write: assert property (@(posedge clk) disable iff (rst)
                (flag_q[i] && !(reg_wr && !reg_sel)) |=> flag_q[i]);
        end
    end
endmodule

bind phy_irq_ctrl phyirq_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .stat_in (stat_in),
    .flag_q  (flag_vec),
    .mask_q  (mask_vec),
    .irq_n   (irq_n),
    .reg_wr  (reg_wr),
    .reg_sel (reg_sel)
);

// File: tb/phy_irq_ctrl_tb.sv
module phy_irq_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 14;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [6:0]  stat_in = 7'b1001000;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        irq_n;

    int nchk = 0;
    int nerr = 0;

    phy_irq_ctrl u_dut (
        .clk       (clk),
        .rst       (rst),
        .stat_in   (stat_in),
        .reg_sel   (reg_sel),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_n     (irq_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // {stat_in, reg_wr, reg_sel, reg_wdata, expected flag register}
    localparam logic [40:0] VEC [NVEC] = '{
        {7'b1001000, 1'b0, 1'b0, 16'h0000, 16'h0080},
        {7'b0001000, 1'b0, 1'b0, 16'h0000, 16'h0000},
        {7'b0001001, 1'b0, 1'b0, 16'h0000, 16'h0002},
        {7'b0001000, 1'b0, 1'b0, 16'h0000, 16'h0002},
        {7'b0001000, 1'b1, 1'b0, 16'h0002, 16'h0000},
        {7'b0000000, 1'b0, 1'b0, 16'h0000, 16'h0010},
        {7'b0000000, 1'b1, 1'b0, 16'h0010, 16'h0010},
        {7'b0001000, 1'b0, 1'b0, 16'h0000, 16'h0010},
        {7'b0001000, 1'b1, 1'b0, 16'h0010, 16'h0000},
        {7'b0111110, 1'b0, 1'b0, 16'h0000, 16'h006C},
        {7'b0111110, 1'b1, 1'b0, 16'hFFFF, 16'h006C},
        {7'b0001000, 1'b1, 1'b0, 16'h0020, 16'h004C},
        {7'b1001000, 1'b1, 1'b0, 16'h0080, 16'h00CC},
        {7'b0001000, 1'b1, 1'b0, 16'hFFFF, 16'h0000}
    };
    localparam string TAG [NVEC] = '{
        "R10", "R10", "R2", "R2", "R4", "R3", "R5",
        "R3", "R4", "R2", "R5", "R4", "R6", "R4"
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
        #1;
    endtask

    task automatic wr_reg(input logic sel, input logic [15:0] data);
        reg_sel = sel;
        reg_wdata = data;
        reg_wr = 1'b1;
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        nerr++;
        nchk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        logic [6:0]  st;
        logic        w;
        logic        s;
        logic [15:0] wd;
        logic [15:0] ex;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // Table walk over flag behaviour
        for (int i = 0; i < NVEC; i++) begin
            {st, w, s, wd, ex} = VEC[i];
            stat_in = st;
            reg_wr = w;
            reg_sel = s;
            reg_wdata = wd;
            tick();
            reg_sel = 1'b0;
            #1;
            chk(TAG[i], reg_rdata, ex);
        end

        // R1: reset state
        stat_in = 7'b1001000;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        reg_sel = 1'b0; #1;
        chk("R1", reg_rdata, 16'h0080);
        reg_sel = 1'b1; #1;
        chk("R1", reg_rdata, 16'h0000);
        chk("R1", {15'b0, irq_n}, 16'h0001);

        // R11: reserved bits read zero after an all-ones mask write
        wr_reg(1'b1, 16'hFFFF);
        reg_sel = 1'b1; #1;
        chk("R11", reg_rdata, 16'h00FE);
        chk("R8", {15'b0, irq_n}, 16'h0001);
        tick();
        chk("R8", {15'b0, irq_n}, 16'h0000);

        // R9: dropping the mask releases the output, flag kept
        wr_reg(1'b1, 16'h0000);
        chk("R9", {15'b0, irq_n}, 16'h0000);
        tick();
        chk("R9", {15'b0, irq_n}, 16'h0001);
        reg_sel = 1'b0; #1;
        chk("R9", reg_rdata, 16'h0080);

        // R7: energy flag set but unmasked, page mask only
        wr_reg(1'b1, 16'h0002);
        tick();
        chk("R7", {15'b0, irq_n}, 16'h0001);

        // R8: page edge reaches the output two edges later
        stat_in = 7'b1001001;
        tick();
        chk("R8", {15'b0, irq_n}, 16'h0001);
        tick();
        chk("R8", {15'b0, irq_n}, 16'h0000);

        // R11: write to bit 0 alone changes nothing
        stat_in = 7'b1001000;
        wr_reg(1'b0, 16'hFF01);
        reg_sel = 1'b0; #1;
        chk("R11", reg_rdata, 16'h0082);

        // R4: clear page flag, output released one edge later
        wr_reg(1'b0, 16'h0002);
        reg_sel = 1'b0; #1;
        chk("R4", reg_rdata, 16'h0080);
        chk("R8", {15'b0, irq_n}, 16'h0000);
        tick();
        chk("R8", {15'b0, irq_n}, 16'h0001);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule